// File: doc/BRIEF.md
# Dual-clock fall-through FIFO

This block is a small first-in first-out buffer, 16 words deep and 5 bits wide, with a write side and a read side that run on unrelated clocks. On each rising edge of the load clock where the load request is high, the block accepts one word. On each rising edge of the unload clock where the unload request is high, it discards the word at the head. The oldest stored word is always driven on the read data bus, so the consumer sees it without asking for it. An unload only advances to the next word.

Four active-low flags report the fill level. The load clock side shows full and one-short-of-full. The unload clock side shows empty and exactly-one-word. Pointers cross between the clock domains in Gray code through two-flop synchronizers. A flag can therefore lag a change made from the other side by a few cycles of its own clock, and it always errs on the safe side. An asynchronous active-low reset clears both sides. A bus enable releases the data bus to high impedance and does not touch the flags.

Top module: `fwft_async_fifo`

## Requirements
- R1: Words leave the FIFO in the order they were accepted, and at most 16 words of 5 bits are held.
- R2: With the flags settled, a load clock edge with `ld_req` high stores `ld_data` if fewer than 16 words are held. An unload clock edge with `ul_req` high removes the head word if at least one word is held.
- R3: A load request while full and an unload request while empty are ignored. The stored words, the head on `ul_data` and every flag are left as they were.
- R4: Once settled, `full_n` is low exactly when 16 words are held and `afull_n` is low exactly when 15 words are held. Full is entered only from the 15-word state.
- R5: Once settled, `empty_n` is low exactly when no word is held and `last_n` is low exactly when one word is held. Empty is entered only from the one-word state.
- R6: While `rst_n` is low, both pointers are cleared, `empty_n` is low, and `full_n`, `afull_n` and `last_n` are high. The data bus value after reset is undefined.
- R7: The first word loaded after reset, or into an empty FIFO, appears on `ul_data` and raises `empty_n` without any unload request.
- R8: With `oe` low, every bit of `ul_data` is high impedance. The flags still show the true fill level.
- R9: While empty, `ul_data` keeps the value of the word that was removed last.
- R10: Each pointer moves by at most one per edge of its own clock, and its Gray copy changes at most one bit per edge. After a load into an empty FIFO, `empty_n` stays low until two unload clock edges have passed, and it is high after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low, for both clock domains |
| ld_clk | input | 1 | Load side clock |
| ld_req | input | 1 | Store `ld_data` on this load clock edge |
| ld_data | input | 5 | Word to store |
| ul_clk | input | 1 | Unload side clock |
| ul_req | input | 1 | Discard the head word on this unload clock edge |
| oe | input | 1 | Drive `ul_data` when high, high impedance when low |
| ul_data | output | 5 | Head word (fall-through), or last removed word while empty |
| full_n | output | 1 | Low when 16 words are held (load clock domain) |
| afull_n | output | 1 | Low when 15 words are held (load clock domain) |
| empty_n | output | 1 | Low when no word is held (unload clock domain) |
| last_n | output | 1 | Low when one word is held (unload clock domain) |

## Verification
The hardest case to reach is a request that has to be refused because the FIFO is exactly at a boundary. A request arriving while the flags are still catching up from the other clock gets a different answer from one arriving after they settle. The stimulus therefore fills and drains in back-to-back bursts on one side only, so that side's own pointer decides the boundary exactly. It then adds one extra load at 16 words and one extra unload at zero words, and checks that neither is accepted. The random phase waits out the synchronizer latency after every request, so that each accept or refuse decision matches the reference queue, and it walks the fill level repeatedly between both ends.

// File: rtl/fwft_async_fifo.sv
module fwft_async_fifo #(
  parameter int W  = 5,
  parameter int AW = 4
) (
  input  logic         rst_n,
  input  logic         ld_clk,
  input  logic         ld_req,
  input  logic [W-1:0] ld_data,
  input  logic         ul_clk,
  input  logic         ul_req,
  input  logic         oe,
  output logic [W-1:0] ul_data,
  output logic         full_n,
  output logic         afull_n,
  output logic         empty_n,
  output logic         last_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr, wgray, rgray;
  logic [PW-1:0] wg_s1, wg_s2, rg_s1, rg_s2;
  logic [PW-1:0] wnext, rnext, rptr_w, wptr_r, wcnt, rcnt;
  logic [W-1:0]  head, hold;
  logic          ld_ok, ul_ok;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  // load clock domain
  assign wnext   = wptr + PW'(1);
  assign rptr_w  = g2b(rg_s2);
  assign wcnt    = wptr - rptr_w;
  assign full_n  = (wcnt != PW'(DEPTH));
  assign afull_n = (wcnt != PW'(DEPTH - 1));
  assign ld_ok   = ld_req && full_n;

  always_ff @(posedge ld_clk or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (ld_ok) begin
      wptr  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
    end

  always_ff @(posedge ld_clk)
    if (ld_ok) mem[wptr[AW-1:0]] <= ld_data;

  always_ff @(posedge ld_clk or negedge rst_n)
    if (!rst_n) {rg_s2, rg_s1} <= '0;
    else        {rg_s2, rg_s1} <= {rg_s1, rgray};

  // unload clock domain
  assign rnext   = rptr + PW'(1);
  assign wptr_r  = g2b(wg_s2);
  assign rcnt    = wptr_r - rptr;
  assign empty_n = (rcnt != '0);
  assign last_n  = (rcnt != PW'(1));
  assign ul_ok   = ul_req && empty_n;
  assign head    = mem[rptr[AW-1:0]];

  always_ff @(posedge ul_clk or negedge rst_n)
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else if (ul_ok) begin
      rptr  <= rnext;
      rgray <= rnext ^ (rnext >> 1);
    end

  always_ff @(posedge ul_clk)
    if (ul_ok) hold <= head;

  always_ff @(posedge ul_clk or negedge rst_n)
    if (!rst_n) {wg_s2, wg_s1} <= '0;
    else        {wg_s2, wg_s1} <= {wg_s1, wgray};

  assign ul_data = oe ? (empty_n ? head : hold) : 'z;
endmodule

// File: rtl/fwft_async_fifo_chk.sv
module fwft_async_fifo_chk #(
  parameter int PW = 5
) (
  input logic          rst_n,
  input logic          ld_clk,
  input logic          ul_clk,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          last_n,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  a_r3_no_overflow: assert property (@(posedge ld_clk) disable iff (!rst_n)
    !full_n |=> $stable(wptr));

  a_r3_no_underflow: assert property (@(posedge ul_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr));

  a_r4_full_after_afull: assert property (@(posedge ld_clk) disable iff (!rst_n)
    (!full_n && $past(full_n)) |-> $past(!afull_n));

  a_r5_empty_after_last: assert property (@(posedge ul_clk) disable iff (!rst_n)
    (!empty_n && $past(empty_n)) |-> $past(!last_n));

  a_r6_reset_flags: assert property (@(posedge ul_clk)
    !rst_n |-> (!empty_n && last_n && full_n && afull_n));

  a_r10_wptr_step: assert property (@(posedge ld_clk) disable iff (!rst_n)
    PW'(wptr - $past(wptr)) <= PW'(1));

  a_r10_rptr_step: assert property (@(posedge ul_clk) disable iff (!rst_n)
    PW'(rptr - $past(rptr)) <= PW'(1));

  a_r10_wgray_onebit: assert property (@(posedge ld_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r10_rgray_onebit: assert property (@(posedge ul_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind fwft_async_fifo fwft_async_fifo_chk #(.PW(PW)) u_chk (
  .rst_n(rst_n), .ld_clk(ld_clk), .ul_clk(ul_clk),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .last_n(last_n),
  .wptr(wptr), .rptr(rptr), .wgray(wgray), .rgray(rgray)
);

// File: tb/fwft_async_fifo_tb.sv
module fwft_async_fifo_tb;
  localparam int W = 5;
  localparam int DEPTH = 16;

  logic rst_n = 1'b1, ld_clk = 1'b0, ul_clk = 1'b0;
  logic ld_req = 1'b0, ul_req = 1'b0, oe = 1'b1;
  logic [W-1:0] ld_data = '0;
  tri1  [W-1:0] dout;
  wire  full_n, afull_n, empty_n, last_n;

  fwft_async_fifo u_dut (
    .rst_n(rst_n), .ld_clk(ld_clk), .ld_req(ld_req), .ld_data(ld_data),
    .ul_clk(ul_clk), .ul_req(ul_req), .oe(oe), .ul_data(dout),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .last_n(last_n)
  );

  always #10 ld_clk = ~ld_clk;
  always #17 ul_clk = ~ul_clk;

  int n_run = 0, n_fail = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] last_out = '0;
  bit have_last = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string req);
    chk({req, "/R4 full_n"},  8'(full_n),  8'(q.size() != DEPTH));
    chk({req, "/R4 afull_n"}, 8'(afull_n), 8'(q.size() != DEPTH - 1));
    chk({req, "/R5 empty_n"}, 8'(empty_n), 8'(q.size() != 0));
    chk({req, "/R5 last_n"},  8'(last_n),  8'(q.size() != 1));
    if (oe) begin
      if (q.size() > 0) chk({req, "/R1 head"}, 8'(dout), 8'(q[0]));
      else if (have_last) chk({req, "/R9 hold"}, 8'(dout), 8'(last_out));
    end
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge ld_clk); ld_req = 1'b1; ld_data = d;
    @(negedge ld_clk); ld_req = 1'b0;
    if (q.size() < DEPTH) q.push_back(d);
  endtask

  task automatic pop();
    @(negedge ul_clk); ul_req = 1'b1;
    @(negedge ul_clk); ul_req = 1'b0;
    if (q.size() > 0) begin
      last_out = q.pop_front();
      have_last = 1;
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge ld_clk);
    repeat (3) @(posedge ul_clk);
    #2;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    #60;
    // R6: reset state
    chk("R6 empty_n", 8'(empty_n), 8'h00);
    chk("R6 last_n",  8'(last_n),  8'h01);
    chk("R6 full_n",  8'(full_n),  8'h01);
    chk("R6 afull_n", 8'(afull_n), 8'h01);
    @(negedge ld_clk); rst_n = 1'b1;
    settle();
    check_state("R6");

    // R10: empty flag lags a load by the synchronizer
    @(negedge ld_clk); ld_req = 1'b1; ld_data = 5'h0A;
    @(posedge ld_clk); #1;
    ld_req = 1'b0;
    q.push_back(5'h0A);
    chk("R10 empty_n still low", 8'(empty_n), 8'h00);
    repeat (3) @(posedge ul_clk);
    #2;
    chk("R10 empty_n high", 8'(empty_n), 8'h01);
    // R7: first word falls through without an unload
    settle();
    chk("R7 head visible", 8'(dout), 8'h0A);
    check_state("R7");

    pop(); settle();
    check_state("R9");
    pop(); settle();               // R3: unload while empty is ignored
    check_state("R3 empty");
    chk("R3 hold unchanged", 8'(dout), 8'h0A);

    // Burst fill to the top, one side only
    for (int i = 0; i < DEPTH - 1; i++) push(W'(i + 3));
    settle();
    check_state("R4 15");
    chk("R4 afull_n low", 8'(afull_n), 8'h00);
    push(5'h1C); settle();
    chk("R4 full_n low", 8'(full_n), 8'h00);
    push(5'h1F); settle();         // R3: load while full is ignored
    check_state("R3 full");
    chk("R1 oldest first", 8'(dout), 8'h03);

    // Burst drain
    pop(); settle();
    check_state("R2 one out");
    for (int i = 0; i < DEPTH - 2; i++) pop();
    settle();
    check_state("R5 one left");
    chk("R5 last_n low", 8'(last_n), 8'h00);
    pop(); pop(); settle();
    check_state("R3 drain");
    chk("R9 hold last", 8'(dout), 8'h1C);

    // R8: bus release, flags intact
    push(5'h00); settle();
    oe = 1'b0; #1;
    chk("R8 bus released", 8'(dout), 8'h1F);
    check_state("R8");
    oe = 1'b1; #1;
    chk("R8 bus driven", 8'(dout), 8'h00);
    pop(); settle();

    // Random walk over the fill level
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 50 + ((n / 60) % 2) * 20 - 10) push(W'($urandom));
      else pop();
      settle();
      check_state("R2 random");
    end

    finish_run();
  end
endmodule